// File: doc/BRIEF.md
# Two-Endpoint Doorbell Link

This block joins two processors, side A and side B, through a pair of mirrored register files that share one clock. Each side has its own 32-bit register port (byte address, write enable, write data, read data) and its own level interrupt line. A sender writes a payload word into its outbox data register. It then writes its outbox message register with the top bit set. That one write copies the message word and the payload into the other side's inbox, flags the inbox as busy and raises the receiver's interrupt.

The receiver handles the message, clears the busy flag and, when it is ready, writes a zero top bit into its inbox-acknowledge register. If the sender's outbox is still marked busy, that write clears the sender's busy bit and latches a completion flag that interrupts the sender. A simpler status channel sends any nonzero word to the peer's status-in register, where a nonzero value is an interrupt source. Each side picks which of its three sources may drive its interrupt line through a control register. Nothing is queued. Software polls the busy bit, or waits for completion, before it sends again.

Top module: `dbl_link`

## Requirements
- R1: After reset every register on both sides reads zero and both interrupt lines are low.
- R2: Writing OUT_MSG (byte offset 0x10) with bit 31 set stores the word locally. On the same clock edge it copies the word into the peer's IN_MSG (0x00) and the local OUT_DATA (0x18) into the peer's IN_DATA (0x08), and sets bit 31 of the peer's IN_ACK (0x04). A write to OUT_MSG with bit 31 clear stores the word and sends nothing.
- R3: Bit 31 of IN_MSG clears only when a 1 is written to that bit. Other bits written to IN_MSG, and all writes to IN_DATA, are ignored.
- R4: Writing IN_ACK with bit 31 = 0 while the peer's OUT_MSG bit 31 is 1 sets bit 31 of the peer's OUT_DONE (0x14), clears the peer's OUT_MSG bit 31 and leaves its other bits unchanged. It also clears the local IN_ACK bit 31.
- R5: The same IN_ACK write while the peer's OUT_MSG bit 31 is 0 changes nothing on the peer.
- R6: OUT_DONE bit 31 stays set until a 1 is written to that bit. Writing 0 leaves it set.
- R7: Writing a nonzero value to STAT_OUT (0x20) copies it into the peer's STAT_IN (0x24). A zero write is stored locally and not sent. A local write to STAT_IN stores the written value, so writing zero clears it.
- R8: CTRL (0x28) holds bits [2:0] and reads zero above them. The interrupt line is (IN_MSG[31] & CTRL[0]) | (OUT_DONE[31] & CTRL[1]) | ((STAT_IN != 0) & CTRL[2]).
- R9: A message sent while the outbox is still busy overwrites the peer's IN_MSG and IN_DATA.
- R10: Offsets 0x0C and 0x1C, offsets at or above 0x2C, and addresses whose low two bits are not zero read as zero and ignore writes.
- R11: When both ports write in the same cycle, each side's own write and the cross-effects from the peer take effect together. An incoming message takes precedence over a local clear of IN_MSG or IN_ACK. A local message write takes precedence over an incoming acknowledge clearing OUT_MSG, and the completion flag is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_we | input | 1 | Side A write enable |
| a_addr | input | 6 | Side A byte address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data (combinational from address) |
| a_irq | output | 1 | Side A interrupt |
| b_we | input | 1 | Side B write enable |
| b_addr | input | 6 | Side B byte address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data (combinational from address) |
| b_irq | output | 1 | Side B interrupt |

## Verification
The handshake is run as a full round trip: send, receiver clear, acknowledge and completion clear. This shows that every step lands on the correct side and touches only the bits it should. Sends with bit 31 clear, and acknowledges while the sender is idle, are tried next to their live versions to separate the gated paths from the ones that always act. A back-to-back send while busy, and zero against nonzero status words, cover the overwrite and the nonzero gate. Same-cycle writes from both ports cover the cases where a crossing effect and a local write hit one register together.

// File: rtl/dbl_pkg.sv
package dbl_pkg;
  // word indices inside one side's register window (byte offset / 4)
  localparam int unsigned IDX_IN_MSG   = 0;
  localparam int unsigned IDX_IN_ACK   = 1;
  localparam int unsigned IDX_IN_DATA  = 2;
  localparam int unsigned IDX_OUT_MSG  = 4;
  localparam int unsigned IDX_OUT_DONE = 5;
  localparam int unsigned IDX_OUT_DATA = 6;
  localparam int unsigned IDX_STAT_OUT = 8;
  localparam int unsigned IDX_STAT_IN  = 9;
  localparam int unsigned IDX_CTRL     = 10;
  localparam int unsigned NUM_SRC      = 3;  // interrupt sources per side
endpackage

// File: rtl/dbl_rst_sync.sv
module dbl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/dbl_irq.sv
module dbl_irq #(
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 3
) (
  input  logic          in_busy,
  input  logic          done,
  input  logic [DW-1:0] stat_in,
  input  logic [CW-1:0] ctrl,
  output logic          irq
);
  logic [CW-1:0] src;

  always_comb begin
    src    = '0;
    src[0] = in_busy;
    src[1] = done;
    src[2] = |stat_in;
    irq    = |(src & ctrl);
  end
endmodule

// File: rtl/dbl_endpoint.sv
module dbl_endpoint
  import dbl_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 6,
  parameter int unsigned CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          peer_busy,
  input  logic          in_msg_vld,
  input  logic [DW-1:0] in_msg,
  input  logic [DW-1:0] in_data,
  input  logic          in_ack,
  input  logic          in_stat_vld,
  input  logic [DW-1:0] in_stat,
  output logic          out_msg_vld,
  output logic [DW-1:0] out_msg,
  output logic [DW-1:0] out_data,
  output logic          out_ack,
  output logic          out_stat_vld,
  output logic [DW-1:0] out_stat,
  output logic          busy,
  output logic          irq
);
  localparam int unsigned TOP = DW - 1;
  localparam int unsigned IW  = AW - 2;

  logic [IW-1:0] widx;
  logic          aligned;
  logic          wr_in_msg, wr_in_ack, wr_in_data, wr_out_msg, wr_out_done;
  logic          wr_out_data, wr_stat_out, wr_stat_in, wr_ctrl;

  assign widx    = addr[AW-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  function automatic logic hit(input logic [IW-1:0] w, input int unsigned k);
    return w == IW'(k);
  endfunction

  always_comb begin
    wr_in_msg   = wr_en && aligned && hit(widx, IDX_IN_MSG);
    wr_in_ack   = wr_en && aligned && hit(widx, IDX_IN_ACK);
    wr_in_data  = wr_en && aligned && hit(widx, IDX_IN_DATA);
    wr_out_msg  = wr_en && aligned && hit(widx, IDX_OUT_MSG);
    wr_out_done = wr_en && aligned && hit(widx, IDX_OUT_DONE);
    wr_out_data = wr_en && aligned && hit(widx, IDX_OUT_DATA);
    wr_stat_out = wr_en && aligned && hit(widx, IDX_STAT_OUT);
    wr_stat_in  = wr_en && aligned && hit(widx, IDX_STAT_IN);
    wr_ctrl     = wr_en && aligned && hit(widx, IDX_CTRL);
  end

  // state
  logic [DW-1:0] in_msg_q, in_data_q, out_msg_q, out_data_q, stat_out_q, stat_in_q;
  logic          in_ack_q, out_done_q;
  logic [CW-1:0] ctrl_q;

  // next state and clock enables
  logic [DW-1:0] in_msg_d, out_msg_d, stat_in_d;
  logic          in_ack_d, out_done_d;
  logic          in_msg_en, in_ack_en, in_data_en, out_msg_en, out_done_en;
  logic          out_data_en, stat_out_en, stat_in_en, ctrl_en;

  always_comb begin
    // incoming message wins over the local busy clear
    in_msg_en   = in_msg_vld || (wr_in_msg && wdata[TOP]);
    in_msg_d    = in_msg_vld ? in_msg : {1'b0, in_msg_q[TOP-1:0]};
    in_ack_en   = in_msg_vld || (wr_in_ack && !wdata[TOP]);
    in_ack_d    = in_msg_vld;
    in_data_en  = in_msg_vld;
    // local message write wins over the incoming acknowledge
    out_msg_en  = wr_out_msg || in_ack;
    out_msg_d   = wr_out_msg ? wdata : {1'b0, out_msg_q[TOP-1:0]};
    out_done_en = in_ack || (wr_out_done && wdata[TOP]);
    out_done_d  = in_ack;
    out_data_en = wr_out_data;
    stat_out_en = wr_stat_out;
    stat_in_en  = in_stat_vld || wr_stat_in;
    stat_in_d   = in_stat_vld ? in_stat : wdata;
    ctrl_en     = wr_ctrl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_msg_q   <= '0;
      in_ack_q   <= 1'b0;
      in_data_q  <= '0;
      out_msg_q  <= '0;
      out_done_q <= 1'b0;
      out_data_q <= '0;
      stat_out_q <= '0;
      stat_in_q  <= '0;
      ctrl_q     <= '0;
    end else begin
      if (in_msg_en)   in_msg_q   <= in_msg_d;
      if (in_ack_en)   in_ack_q   <= in_ack_d;
      if (in_data_en)  in_data_q  <= in_data;
      if (out_msg_en)  out_msg_q  <= out_msg_d;
      if (out_done_en) out_done_q <= out_done_d;
      if (out_data_en) out_data_q <= wdata;
      if (stat_out_en) stat_out_q <= wdata;
      if (stat_in_en)  stat_in_q  <= stat_in_d;
      if (ctrl_en)     ctrl_q     <= wdata[CW-1:0];
    end
  end

  // crossing effects toward the peer
  always_comb begin
    out_msg_vld  = wr_out_msg && wdata[TOP];
    out_msg      = wdata;
    out_data     = out_data_q;
    out_ack      = wr_in_ack && !wdata[TOP] && peer_busy;
    out_stat_vld = wr_stat_out && (wdata != '0);
    out_stat     = wdata;
    busy         = out_msg_q[TOP];
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (aligned) begin
      unique case (int'(widx))
        IDX_IN_MSG:   rdata = in_msg_q;
        IDX_IN_ACK:   rdata = {in_ack_q, {(DW-1){1'b0}}};
        IDX_IN_DATA:  rdata = in_data_q;
        IDX_OUT_MSG:  rdata = out_msg_q;
        IDX_OUT_DONE: rdata = {out_done_q, {(DW-1){1'b0}}};
        IDX_OUT_DATA: rdata = out_data_q;
        IDX_STAT_OUT: rdata = stat_out_q;
        IDX_STAT_IN:  rdata = stat_in_q;
        IDX_CTRL:     rdata = {{(DW-CW){1'b0}}, ctrl_q};
        default:      rdata = '0;
      endcase
    end
  end

  dbl_irq #(.DW(DW), .CW(CW)) u_irq (
    .in_busy (in_msg_q[TOP]),
    .done    (out_done_q),
    .stat_in (stat_in_q),
    .ctrl    (ctrl_q),
    .irq     (irq)
  );

  // R2
  msg_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_msg_vld |=> (in_msg_q == $past(in_msg)) && in_ack_q && (in_data_q == $past(in_data)));

  // R4
  ack_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ack && !wr_out_msg) |=> !out_msg_q[TOP] && out_done_q);

  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done_q && !(wr_out_done && wdata[TOP])) |=> out_done_q);

  // R3
  inbox_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_msg_vld |=> $stable(in_data_q));

  // R7
  stat_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_stat_vld |=> (stat_in_q == $past(in_stat)));
endmodule

// File: rtl/dbl_link.sv
module dbl_link #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 6,
  parameter int unsigned CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_irq,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_irq
);
  logic rst_n_s;

  dbl_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_n_s)
  );

  logic          a2b_msg_vld, b2a_msg_vld, a2b_ack, b2a_ack;
  logic          a2b_stat_vld, b2a_stat_vld, a_busy, b_busy;
  logic [DW-1:0] a2b_msg, b2a_msg, a2b_data, b2a_data, a2b_stat, b2a_stat;

  dbl_endpoint #(.DW(DW), .AW(AW), .CW(CW)) u_side_a (
    .clk(clk), .rst_n(rst_n_s),
    .wr_en(a_we), .addr(a_addr), .wdata(a_wdata), .rdata(a_rdata),
    .peer_busy(b_busy),
    .in_msg_vld(b2a_msg_vld), .in_msg(b2a_msg), .in_data(b2a_data),
    .in_ack(b2a_ack), .in_stat_vld(b2a_stat_vld), .in_stat(b2a_stat),
    .out_msg_vld(a2b_msg_vld), .out_msg(a2b_msg), .out_data(a2b_data),
    .out_ack(a2b_ack), .out_stat_vld(a2b_stat_vld), .out_stat(a2b_stat),
    .busy(a_busy), .irq(a_irq)
  );

  dbl_endpoint #(.DW(DW), .AW(AW), .CW(CW)) u_side_b (
    .clk(clk), .rst_n(rst_n_s),
    .wr_en(b_we), .addr(b_addr), .wdata(b_wdata), .rdata(b_rdata),
    .peer_busy(a_busy),
    .in_msg_vld(a2b_msg_vld), .in_msg(a2b_msg), .in_data(a2b_data),
    .in_ack(a2b_ack), .in_stat_vld(a2b_stat_vld), .in_stat(a2b_stat),
    .out_msg_vld(b2a_msg_vld), .out_msg(b2a_msg), .out_data(b2a_data),
    .out_ack(b2a_ack), .out_stat_vld(b2a_stat_vld), .out_stat(b2a_stat),
    .busy(b_busy), .irq(b_irq)
  );

  // R5
  ack_gate_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!a_busy && !a_we) |=> !a_busy);
endmodule

// File: tb/dbl_link_tb.sv
module dbl_link_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        a_we, b_we;
  logic [5:0]  a_addr, b_addr;
  logic [31:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic        a_irq, b_irq;
  int          n_tests = 0;
  int          n_fail  = 0;
  bit          done_flag = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  dbl_link u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_irq(a_irq),
    .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_irq(b_irq)
  );

  typedef struct packed {
    logic        ws;  // write side: 0=A 1=B
    logic        we;
    logic [5:0]  wa;
    logic [31:0] wd;
    logic        rs;  // read side
    logic [5:0]  ra;
    logic [31:0] ex;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,6'h18,32'hDEAD0001, 1'b0,6'h18,32'hDEAD0001, 8'd2},  // R2 payload
    '{1'b0,1'b1,6'h10,32'h80000055, 1'b1,6'h00,32'h80000055, 8'd2},  // R2 send
    '{1'b0,1'b0,6'h00,32'h0,        1'b1,6'h08,32'hDEAD0001, 8'd2},  // R2
    '{1'b0,1'b0,6'h00,32'h0,        1'b1,6'h04,32'h80000000, 8'd2},  // R2
    '{1'b0,1'b0,6'h00,32'h0,        1'b0,6'h10,32'h80000055, 8'd2},  // R2
    '{1'b1,1'b1,6'h00,32'h0000FFFF, 1'b1,6'h00,32'h80000055, 8'd3},  // R3
    '{1'b1,1'b1,6'h08,32'h12345678, 1'b1,6'h08,32'hDEAD0001, 8'd3},  // R3
    '{1'b1,1'b1,6'h00,32'h80000000, 1'b1,6'h00,32'h00000055, 8'd3},  // R3
    '{1'b1,1'b1,6'h04,32'h00000000, 1'b0,6'h14,32'h80000000, 8'd4},  // R4
    '{1'b0,1'b0,6'h00,32'h0,        1'b0,6'h10,32'h00000055, 8'd4},  // R4
    '{1'b0,1'b0,6'h00,32'h0,        1'b1,6'h04,32'h00000000, 8'd4},  // R4
    '{1'b0,1'b1,6'h14,32'h00000000, 1'b0,6'h14,32'h80000000, 8'd6},  // R6
    '{1'b0,1'b1,6'h14,32'h80000000, 1'b0,6'h14,32'h00000000, 8'd6},  // R6
    '{1'b1,1'b1,6'h04,32'h00000000, 1'b0,6'h14,32'h00000000, 8'd5},  // R5
    '{1'b0,1'b0,6'h00,32'h0,        1'b0,6'h10,32'h00000055, 8'd5},  // R5
    '{1'b0,1'b1,6'h10,32'h00000077, 1'b1,6'h00,32'h00000055, 8'd2},  // R2 no send
    '{1'b0,1'b0,6'h00,32'h0,        1'b1,6'h04,32'h00000000, 8'd2},  // R2
    '{1'b0,1'b1,6'h10,32'h80000011, 1'b1,6'h00,32'h80000011, 8'd9},  // R9
    '{1'b0,1'b1,6'h10,32'h80000022, 1'b1,6'h00,32'h80000022, 8'd9},  // R9
    '{1'b0,1'b1,6'h20,32'h000000A5, 1'b1,6'h24,32'h000000A5, 8'd7},  // R7
    '{1'b0,1'b1,6'h20,32'h00000000, 1'b1,6'h24,32'h000000A5, 8'd7},  // R7
    '{1'b0,1'b0,6'h00,32'h0,        1'b0,6'h20,32'h00000000, 8'd7},  // R7
    '{1'b1,1'b1,6'h24,32'h00000000, 1'b1,6'h24,32'h00000000, 8'd7},  // R7
    '{1'b0,1'b1,6'h0C,32'hFFFFFFFF, 1'b0,6'h0C,32'h00000000, 8'd10}, // R10
    '{1'b0,1'b1,6'h1C,32'hFFFFFFFF, 1'b0,6'h1C,32'h00000000, 8'd10}, // R10
    '{1'b0,1'b1,6'h2C,32'hFFFFFFFF, 1'b0,6'h3C,32'h00000000, 8'd10}, // R10
    '{1'b0,1'b1,6'h19,32'h11111111, 1'b0,6'h18,32'hDEAD0001, 8'd10}, // R10 misaligned
    '{1'b0,1'b0,6'h00,32'h0,        1'b0,6'h2C,32'h00000000, 8'd10}, // R10
    '{1'b0,1'b1,6'h28,32'hFFFFFFFF, 1'b0,6'h28,32'h00000007, 8'd8}   // R8
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic side, input logic [5:0] ad, input logic [31:0] d);
    @(negedge clk);
    if (!side) begin a_we = 1'b1; a_addr = ad; a_wdata = d; end
    else       begin b_we = 1'b1; b_addr = ad; b_wdata = d; end
    @(negedge clk);
    a_we = 1'b0; b_we = 1'b0;
  endtask

  task automatic wr2(input logic [5:0] aa, input logic [31:0] ad,
                     input logic [5:0] ba, input logic [31:0] bd);
    @(negedge clk);
    a_we = 1'b1; a_addr = aa; a_wdata = ad;
    b_we = 1'b1; b_addr = ba; b_wdata = bd;
    @(negedge clk);
    a_we = 1'b0; b_we = 1'b0;
  endtask

  task automatic rd_chk(input logic side, input logic [5:0] ad, input logic [31:0] exp,
                        input string tag);
    if (!side) a_addr = ad; else b_addr = ad;
    #1;
    check(tag, side ? b_rdata : a_rdata, exp);
  endtask

  task automatic irq_chk(input logic side, input logic exp, input string tag);
    #1;
    check(tag, {31'b0, side ? b_irq : a_irq}, {31'b0, exp});
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic reset_checks(input string tag);
    for (int s = 0; s < 2; s++) begin
      for (int w = 0; w < 11; w++) rd_chk(s[0], 6'(w * 4), 32'h0, tag);
      irq_chk(s[0], 1'b0, tag);
    end
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    a_we = 1'b0; b_we = 1'b0; a_addr = '0; b_addr = '0; a_wdata = '0; b_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    reset_checks("R1 reset");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].we) wr(VEC[i].ws, VEC[i].wa, VEC[i].wd);
      rd_chk(VEC[i].rs, VEC[i].ra, VEC[i].ex, $sformatf("R%0d vec %0d", VEC[i].rq, i));
    end

    // R8: interrupt gating and sources (B holds a busy message, CTRL_B = 0)
    irq_chk(1'b1, 1'b0, "R8 masked busy");
    wr(1'b1, 6'h28, 32'h1);
    irq_chk(1'b1, 1'b1, "R8 busy enabled");
    wr(1'b1, 6'h00, 32'h80000000);
    irq_chk(1'b1, 1'b0, "R8 busy cleared");
    irq_chk(1'b0, 1'b0, "R8 A idle");
    wr(1'b1, 6'h04, 32'h0);
    irq_chk(1'b0, 1'b1, "R8 R4 done irq");
    wr(1'b0, 6'h14, 32'h80000000);
    irq_chk(1'b0, 1'b0, "R8 R6 done cleared");
    wr(1'b1, 6'h20, 32'h3);
    irq_chk(1'b0, 1'b1, "R8 R7 status irq");
    rd_chk(1'b0, 6'h24, 32'h3, "R7 status copy");
    wr(1'b0, 6'h24, 32'h0);
    irq_chk(1'b0, 1'b0, "R8 R7 status cleared");

    // R11: both sides send in the same cycle
    wr2(6'h10, 32'h80000033, 6'h10, 32'h80000044);
    rd_chk(1'b0, 6'h00, 32'h80000044, "R11 A inbox");
    rd_chk(1'b1, 6'h00, 32'h80000033, "R11 B inbox");
    rd_chk(1'b1, 6'h08, 32'hDEAD0001, "R11 B inbox data");
    // R11: A sends again while B acknowledges the previous message
    wr2(6'h10, 32'h80000099, 6'h04, 32'h0);
    rd_chk(1'b0, 6'h10, 32'h80000099, "R11 A outbox kept");
    rd_chk(1'b0, 6'h14, 32'h80000000, "R11 A done set");
    rd_chk(1'b1, 6'h00, 32'h80000099, "R11 B new message");
    rd_chk(1'b1, 6'h04, 32'h80000000, "R11 B ack flag set");

    // R1: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    reset_checks("R1 async reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    reset_checks("R1 after release");

    finish_run();
  end
endmodule